// File: doc/BRIEF.md
# Serial Radio Packet Framer

This block turns one outgoing radio packet into a serial bit stream. A start request carries the packet settings: the receiver address (3 to 5 bytes), the payload length, the packet-control options and the CRC options. The framer then sends the packet, most significant bit first, one bit per valid/ready handshake. It sends a synchronisation byte, the address, an optional 9-bit control word, the payload bytes and an optional checksum of one or two bytes. Payload bytes are pulled one at a time from a simple valid/ready byte port while the packet is being sent.

The synchronisation byte is an alternating pattern whose phase follows the first address bit. The control word holds the length, a two-bit rolling sequence number and a "do not acknowledge" flag. It is present whenever acknowledgement or variable-length mode is in use. Either of those modes also forces the checksum on. A start request whose length or address width is out of range is refused with a one-cycle pulse and has no other effect.

Top module: `pkt_framer`

## Requirements
- R1: The first eight bits are 1,0,1,0,1,0,1,0 when the first address bit (bit 8*N-1 of the address input, N = address width in bytes) is 1, and 0,1,0,1,0,1,0,1 when it is 0.
- R2: After the first byte, the framer sends bits 8*N-1 down to 0 of the address input, where N is the address width (3, 4 or 5).
- R3: When variable-length mode or acknowledgement is on, 9 control bits follow the address, in this order: length[5:0], sequence number[1:0], no-ack flag. When both modes are off, no control bits are sent.
- R4: The 2-bit sequence number sent is the previous value plus one (mod 4) for a new packet, and equal to the previous value for a retransmission. After reset the previous value is 0.
- R5: The payload port requests exactly `len_i` bytes. Each byte is sent MSB first, in arrival order. The byte request is raised only while no bit is offered.
- R6: With the narrow checksum, 8 bits follow the payload. They are computed with polynomial 0x07 (x^8+x^2+x+1), start value 0xFF, no final inversion, over the address, control and payload bits in the order sent, and sent MSB first.
- R7: With the wide checksum, 16 bits follow the payload. They are computed with polynomial 0x1021 (x^16+x^12+x^5+1), start value 0xFFFF, over the same bits, and sent MSB first.
- R8: The checksum is sent when the checksum enable, acknowledgement or variable-length mode is on, and is left out only when all three are off.
- R9: A start request with length 0, a length above 32, or an address width outside 3..5 is refused. `reject_o` pulses for one cycle, no bit is offered, and the sequence number does not change.
- R10: `done_o` is high for exactly one cycle, the cycle right after the final bit transfer. A start request seen while busy is ignored.
- R11: While `bit_valid_o` is high and `bit_ready_i` is low, the offered bit and its valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Packet start request, taken only when idle |
| addr_i | input | 40 | Receiver address, right-aligned |
| addr_bytes_i | input | 3 | Address width in bytes (3..5) |
| len_i | input | 6 | Payload length in bytes (1..32) |
| crc_en_i | input | 1 | Checksum enable |
| crc_wide_i | input | 1 | 1: 16-bit checksum, 0: 8-bit checksum |
| auto_ack_i | input | 1 | Acknowledgement mode |
| dyn_len_i | input | 1 | Variable-length mode |
| no_ack_i | input | 1 | No-ack flag for the control word |
| retx_i | input | 1 | Retransmission: keep the sequence number |
| pl_data_i | input | 8 | Payload byte |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_ready_o | output | 1 | Payload byte requested |
| bit_o | output | 1 | Serial output bit |
| bit_valid_o | output | 1 | Output bit valid |
| bit_ready_i | input | 1 | Sink takes the bit |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |
| reject_o | output | 1 | One-cycle pulse for a refused start |

## Verification
A wrong field counter or a wrong state transition shows up on the serial stream as a shifted or truncated field. It is seen in the same packet, at the first bit of the field that follows. A corrupted checksum register or a wrong feedback tap only becomes visible in the last 8 or 16 bits of the packet. A sequence-number fault is seen in the control word of the next packet that has the control word enabled. The bench therefore compares every packet bit by bit against a model built separately. It sweeps all address widths and all option combinations, with and without backpressure.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_ADDR  = 3'd2,
    ST_CTRL  = 3'd3,
    ST_FETCH = 3'd4,
    ST_PBITS = 3'd5,
    ST_CSUM  = 3'd6
  } pf_state_e;

  localparam int SYNC_BITS = 8;
  localparam int CTRL_BITS = 9;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/pf_crc_serial.sv
module pf_crc_serial #(
  parameter logic [15:0] POLY_WIDE   = 16'h1021,
  parameter logic [7:0]  POLY_NARROW = 8'h07,
  parameter logic [15:0] SEED_WIDE   = 16'hFFFF,
  parameter logic [7:0]  SEED_NARROW = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_i,
  input  logic        wide_i,
  input  logic        step_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d;
  logic        fb;

  always_comb begin
    crc_d = crc_q;
    fb    = 1'b0;
    if (seed_i) begin
      crc_d = wide_i ? SEED_WIDE : {8'h00, SEED_NARROW};
    end else if (step_i) begin
      if (wide_i) begin
        fb    = bit_i ^ crc_q[15];
        crc_d = {crc_q[14:0], 1'b0} ^ (fb ? POLY_WIDE : 16'h0000);
      end else begin
        fb    = bit_i ^ crc_q[7];
        crc_d = {8'h00, ({crc_q[6:0], 1'b0} ^ (fb ? POLY_NARROW : 8'h00))};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 16'h0000;
    end else if (seed_i || step_i) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pf_seq_id.sv
module pf_seq_id #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [ID_W-1:0] cur_o,
  output logic [ID_W-1:0] nxt_o
);
  logic [ID_W-1:0] id_q;

  assign nxt_o = id_q + 1'b1;
  assign cur_o = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (adv_i) begin
      id_q <= nxt_o;
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pf_pkg::*;
#(
  parameter int MAX_ADDR_BYTES = 5,
  parameter int MIN_ADDR_BYTES = 3,
  parameter int MAX_LEN        = 32,
  parameter int LEN_W          = 6,
  parameter int ID_W           = 2,
  localparam int ADDR_W        = 8 * MAX_ADDR_BYTES,
  localparam int AWB_W         = $clog2(MAX_ADDR_BYTES + 1),
  localparam int CNT_W         = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [AWB_W-1:0]  addr_bytes_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              crc_en_i,
  input  logic              crc_wide_i,
  input  logic              auto_ack_i,
  input  logic              dyn_len_i,
  input  logic              no_ack_i,
  input  logic              retx_i,
  input  logic [7:0]        pl_data_i,
  input  logic              pl_valid_i,
  output logic              pl_ready_o,
  output logic              bit_o,
  output logic              bit_valid_o,
  input  logic              bit_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o
);
  localparam logic [AWB_W-1:0] MAXB = AWB_W'(MAX_ADDR_BYTES);
  localparam logic [AWB_W-1:0] MINB = AWB_W'(MIN_ADDR_BYTES);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_LEN);
  localparam int               CW   = LEN_W + ID_W + 1;

  pf_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     ctrl_q;
  logic [CNT_W-1:0]  abits_q;
  logic              first_q, ctrl_on_q, csum_on_q, wide_q;
  logic              done_q, reject_q;

  logic              idle, len_ok, aw_ok, accept, refuse, xfer, last_bit, finish;
  logic [AWB_W-1:0]  pad_b;
  logic [ADDR_W-1:0] addr_al;
  logic [ID_W-1:0]   id_cur, id_nxt, id_sel;
  logic [15:0]       crc_v;
  logic              crc_step;

  // start qualification
  assign idle    = (state_q == ST_IDLE);
  assign len_ok  = (len_i != '0) && (len_i <= MAXL);
  assign aw_ok   = (addr_bytes_i >= MINB) && (addr_bytes_i <= MAXB);
  assign accept  = start_i && idle && len_ok && aw_ok;
  assign refuse  = start_i && idle && !(len_ok && aw_ok);
  assign pad_b   = MAXB - addr_bytes_i;
  assign addr_al = addr_i << {pad_b, 3'b000};
  assign id_sel  = retx_i ? id_cur : id_nxt;

  pf_seq_id #(.ID_W(ID_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (accept && !retx_i),
    .cur_o (id_cur),
    .nxt_o (id_nxt)
  );

  // handshake and bit source
  assign bit_valid_o = (state_q == ST_SYNC) || (state_q == ST_ADDR) ||
                       (state_q == ST_CTRL) || (state_q == ST_PBITS) ||
                       (state_q == ST_CSUM);
  assign pl_ready_o  = (state_q == ST_FETCH);
  assign xfer        = bit_valid_o && bit_ready_i;
  assign last_bit    = xfer && (cnt_q == '0);
  assign crc_step    = xfer && ((state_q == ST_ADDR) || (state_q == ST_CTRL) ||
                                (state_q == ST_PBITS));

  always_comb begin
    unique case (state_q)
      ST_SYNC:                    bit_o = cnt_q[0] ? first_q : ~first_q;
      ST_ADDR, ST_CTRL, ST_PBITS: bit_o = sh_q[ADDR_W-1];
      ST_CSUM:                    bit_o = crc_v[cnt_q[3:0]];
      default:                    bit_o = 1'b0;
    endcase
  end

  pf_crc_serial u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed_i (accept),
    .wide_i (accept ? crc_wide_i : wide_q),
    .step_i (crc_step),
    .bit_i  (sh_q[ADDR_W-1]),
    .crc_o  (crc_v)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    sh_d    = sh_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SYNC;
          cnt_d   = CNT_W'(SYNC_BITS - 1);
          left_d  = len_i;
          sh_d    = addr_al;
        end
      end
      ST_SYNC: begin
        if (xfer) begin
          cnt_d = cnt_q - 1'b1;
          if (last_bit) begin
            state_d = ST_ADDR;
            cnt_d   = abits_q;
          end
        end
      end
      ST_ADDR: begin
        if (xfer) begin
          cnt_d = cnt_q - 1'b1;
          sh_d  = {sh_q[ADDR_W-2:0], 1'b0};
          if (last_bit) begin
            if (ctrl_on_q) begin
              state_d = ST_CTRL;
              cnt_d   = CNT_W'(CTRL_BITS - 1);
              sh_d    = {ctrl_q, {(ADDR_W-CW){1'b0}}};
            end else begin
              state_d = ST_FETCH;
            end
          end
        end
      end
      ST_CTRL: begin
        if (xfer) begin
          cnt_d = cnt_q - 1'b1;
          sh_d  = {sh_q[ADDR_W-2:0], 1'b0};
          if (last_bit) state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (pl_valid_i) begin
          state_d = ST_PBITS;
          cnt_d   = CNT_W'(BYTE_BITS - 1);
          sh_d    = {pl_data_i, {(ADDR_W-8){1'b0}}};
        end
      end
      ST_PBITS: begin
        if (xfer) begin
          cnt_d = cnt_q - 1'b1;
          sh_d  = {sh_q[ADDR_W-2:0], 1'b0};
          if (last_bit) begin
            left_d = left_q - 1'b1;
            if (left_q != LEN_W'(1)) begin
              state_d = ST_FETCH;
            end else if (csum_on_q) begin
              state_d = ST_CSUM;
              cnt_d   = wide_q ? CNT_W'(15) : CNT_W'(7);
            end else begin
              state_d = ST_IDLE;
              finish  = 1'b1;
            end
          end
        end
      end
      ST_CSUM: begin
        if (xfer) begin
          cnt_d = cnt_q - 1'b1;
          if (last_bit) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      left_q   <= left_d;
      sh_q     <= sh_d;
      done_q   <= finish;
      reject_q <= refuse;
    end
  end

  // per-packet settings, loaded on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      abits_q   <= '0;
      first_q   <= 1'b0;
      ctrl_on_q <= 1'b0;
      csum_on_q <= 1'b0;
      wide_q    <= 1'b0;
    end else if (accept) begin
      ctrl_q    <= {len_i, id_sel, no_ack_i};
      abits_q   <= CNT_W'({addr_bytes_i, 3'b000} - 1'b1);
      first_q   <= addr_al[ADDR_W-1];
      ctrl_on_q <= dyn_len_i || auto_ack_i;
      csum_on_q <= crc_en_i || dyn_len_i || auto_ack_i;
      wide_q    <= crc_wide_i;
    end
  end

  assign busy_o   = !idle;
  assign done_o   = done_q;
  assign reject_o = reject_q;
endmodule

// File: rtl/pf_checker.sv
module pf_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic bit_o,
  input logic bit_valid_o,
  input logic bit_ready_i,
  input logic pl_ready_o,
  input logic busy_o,
  input logic done_o,
  input logic reject_o
);
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o && !bit_ready_i |=> bit_valid_o && $stable(bit_o)); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bit_valid_o && bit_ready_i)); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R10
  AST_FETCH_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready_o |-> busy_o && !bit_valid_o); // R5
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> !busy_o && !bit_valid_o && $past(start_i)); // R9
endmodule

bind pkt_framer pf_checker u_pf_checker (.*);

// File: tb/pkt_framer_test.sv
module pkt_framer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, crc_en_i, crc_wide_i, auto_ack_i, dyn_len_i, no_ack_i, retx_i;
  logic [39:0] addr_i;
  logic [2:0]  addr_bytes_i;
  logic [5:0]  len_i;
  logic [7:0]  pl_data_i;
  logic        pl_valid_i, pl_ready_o, bit_o, bit_valid_o, bit_ready_i;
  logic        busy_o, done_o, reject_o;

  pkt_framer uut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int pid_m  = 0;

  bit  expv[0:511];
  int  expr[0:511];
  int  nexp;
  bit  rxv[0:511];
  int  got;
  logic [15:0] crc_m;
  bit  wide_m;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv_i);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv_i);
    end
  endtask

  function automatic string rname(input int r);
    case (r)
      1: return "R1 sync byte";
      2: return "R2 address";
      3: return "R3,R4 control word";
      5: return "R5 payload";
      6: return "R6,R8 narrow checksum";
      default: return "R7,R8 wide checksum";
    endcase
  endfunction

  function automatic logic [7:0] pbyte(input int j, input int len);
    return 8'((j * 29) + (len * 3) + 165);
  endfunction

  task automatic push(input bit b, input int r, input bit upd);
    bit fb;
    expv[nexp] = b;
    expr[nexp] = r;
    nexp++;
    if (upd) begin
      if (wide_m) begin
        fb = b ^ crc_m[15];
        crc_m = {crc_m[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end else begin
        fb = b ^ crc_m[7];
        crc_m = {8'h00, ({crc_m[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00))};
      end
    end
  endtask

  task automatic run_packet(input int aw, input int len, input bit cen, input bit wide,
                            input bit ack, input bit dyn, input bit noack, input bit retx,
                            input logic [39:0] addr, input int bp, input bit poke);
    bit first, prev_last, fin;
    int fed, donecnt, cyc;
    logic [8:0] ctrl;
    nexp = 0;
    got  = 0;
    if (!retx) pid_m = (pid_m + 1) % 4;
    wide_m = wide;
    crc_m  = wide ? 16'hFFFF : 16'h00FF;
    first  = addr[8*aw-1];
    for (int i = 7; i >= 0; i--) push((i % 2 == 1) ? first : ~first, 1, 1'b0);
    for (int i = 8*aw-1; i >= 0; i--) push(addr[i], 2, 1'b1);
    if (ack || dyn) begin
      ctrl = {6'(len), 2'(pid_m), noack};
      for (int i = 8; i >= 0; i--) push(ctrl[i], 3, 1'b1);
    end
    for (int j = 0; j < len; j++)
      for (int i = 7; i >= 0; i--) push(pbyte(j, len)[i], 5, 1'b1);
    if (cen || ack || dyn)
      for (int i = (wide ? 15 : 7); i >= 0; i--) push(crc_m[i], wide ? 7 : 6, 1'b0);

    @(negedge clk);
    addr_i = addr; addr_bytes_i = 3'(aw); len_i = 6'(len);
    crc_en_i = cen; crc_wide_i = wide; auto_ack_i = ack; dyn_len_i = dyn;
    no_ack_i = noack; retx_i = retx; start_i = 1'b1;
    fed = 0; donecnt = 0; cyc = 0; prev_last = 1'b0; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (poke && cyc == 20) begin
        start_i = 1'b1; len_i = 6'd7; retx_i = 1'b0; addr_bytes_i = 3'd3;
      end
      if (done_o) begin
        donecnt++;
        check(prev_last, "R10 done timing", 0, 1);
      end
      prev_last = 1'b0;
      bit_ready_i = (bp == 0) ? 1'b1 : ((cyc % (bp + 2)) != 0);
      if (bit_valid_o && bit_ready_i) begin
        if (got < 512) rxv[got] = bit_o;
        got++;
        if (got == nexp) prev_last = 1'b1;
      end
      if (pl_ready_o && !(bp == 2 && cyc % 3 == 0)) begin
        pl_valid_i = 1'b1;
        pl_data_i  = pbyte(fed, len);
        fed++;
      end else begin
        pl_valid_i = 1'b0;
      end
      if (donecnt > 0 && !busy_o) fin = 1'b1;
      if (cyc > 4000) begin
        check(1'b0, "R10 packet never finished", cyc, nexp);
        fin = 1'b1;
      end
    end
    pl_valid_i = 1'b0;
    bit_ready_i = 1'b0;
    @(negedge clk);
    check(!done_o, "R10 done single pulse", done_o, 0);
    check(got == nexp, "R8,R11 stream length", got, nexp);
    check(fed == len, "R5 bytes requested", fed, len);
    for (int r = 1; r <= 7; r++) begin
      int present, bad;
      present = 0; bad = 0;
      for (int i = 0; i < nexp; i++)
        if (expr[i] == r) begin
          present = 1;
          if (i >= got || rxv[i] != expv[i]) bad++;
        end
      if (present != 0) check(bad == 0, rname(r), bad, 0);
    end
  endtask

  task automatic try_refuse(input int aw, input int len, input string tag);
    @(negedge clk);
    addr_bytes_i = 3'(aw); len_i = 6'(len); start_i = 1'b1; retx_i = 1'b0;
    bit_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(reject_o == 1'b1, tag, reject_o, 1);
    check(!busy_o && !bit_valid_o, tag, bit_valid_o, 0);
    @(negedge clk);
    check(!reject_o && !bit_valid_o, tag, reject_o, 0);
    bit_ready_i = 1'b0;
  endtask

  initial begin
    logic [39:0] a;
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; addr_bytes_i = 3'd5; len_i = 6'd1;
    crc_en_i = 1'b0; crc_wide_i = 1'b0; auto_ack_i = 1'b0; dyn_len_i = 1'b0;
    no_ack_i = 1'b0; retx_i = 1'b0; pl_data_i = '0; pl_valid_i = 1'b0; bit_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !bit_valid_o && !pl_ready_o && !done_o && !reject_o,
          "R10 reset state", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int aw = 3; aw <= 5; aw++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        a = 40'hC35A_96E1_0F ^ (40'(cfg) * 40'h01_2345_6789);
        a[8*aw-1] = cfg[1] ^ aw[0];
        run_packet(aw, ((aw * 16 + cfg) * 11) % 32 + 1, cfg[0], cfg[1], cfg[2], cfg[3],
                   cfg[0] ^ aw[0], (cfg % 5) == 4, a, (aw + cfg) % 3, 1'b0);
      end
    end
    // length boundaries, wrap of sequence number, busy-time start ignored
    run_packet(5, 32, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFF_0000_00AA, 1, 1'b0);
    run_packet(3, 1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 40'h00_0012_3456, 0, 1'b0);
    run_packet(4, 12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_8765_4321, 0, 1'b1);
    run_packet(4, 3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_1765_4321, 2, 1'b0);
    // refused starts, followed by a packet that shows the sequence number kept
    try_refuse(5, 33, "R9 length 33");
    try_refuse(5, 0,  "R9 length 0");
    try_refuse(2, 8,  "R9 width 2");
    try_refuse(6, 8,  "R9 width 6");
    run_packet(3, 4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 40'h00_00A1_B2C3, 0, 1'b0);
    run_packet(3, 4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 40'h00_00A1_B2C3, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule